// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

This block is an eight-bit storage register (width set by a parameter) that, on each rising clock edge, holds its contents, shifts toward the high end, shifts toward the low end, or loads all bits at once. A two-bit mode select picks the operation. An active-low master reset clears the register at once, without waiting for the clock.

The parallel data path is a shared bidirectional bus. Here it is brought out as three signals: a data input, a data output and a drive enable that tells the pad ring when to turn on its drivers. The block turns the drivers off when either of two active-low output enables is high. It also turns them off whenever load mode is selected, so that an outside agent can put the load value onto the bus.

The lowest and highest register bits also leave on two dedicated serial outputs. These are never turned off. Several registers can be chained by wiring one stage's serial output to the next stage's serial input.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode_sel = 2'b11, a rising clock edge copies bus_in[n] into register bit n for every n.
- R2: With mode_sel = 2'b01, a rising clock edge moves each bit n to bit n+1 and puts ser_in_up into bit 0.
- R3: With mode_sel = 2'b10, a rising clock edge moves each bit n to bit n-1 and puts ser_in_dn into bit W-1.
- R4: With mode_sel = 2'b00, a rising clock edge leaves the register unchanged, whatever the serial and bus inputs are.
- R5: rst_n low clears every register bit to 0 at once, without a clock edge. It overrides mode_sel and the clock for as long as it stays low.
- R6: bus_oe is 0 whenever oe_a_n or oe_b_n is 1.
- R7: bus_oe is 0 whenever mode_sel = 2'b11, whatever the enables are.
- R8: bus_oe is 1 when both enables are 0 and mode_sel is not 2'b11. bus_out carries the current register value at all times.
- R9: Load, shift, hold and reset work the same with bus_oe at 0 as with bus_oe at 1.
- R10: ser_out_lo equals register bit 0 and ser_out_hi equals bit W-1 in every cycle. Both follow the register with no extra delay and are never disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_up | input | 1 | Serial bit entering bit 0 on an up shift |
| ser_in_dn | input | 1 | Serial bit entering bit W-1 on a down shift |
| oe_a_n | input | 1 | Active-low bus output enable A |
| oe_b_n | input | 1 | Active-low bus output enable B |
| bus_in | input | W | Value read from the shared bus pins |
| bus_out | output | W | Register value offered to the bus drivers |
| bus_oe | output | 1 | Bus driver enable, high when the block drives the bus |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register bit W-1 |

## Verification
The hardest case to reach is a reset that falls between clock edges while load mode is selected and a full-ones value sits on the bus. Only a reset that acts without the clock empties the register in that window. The bench first loads all ones, then drops rst_n in the middle of a cycle with load still selected, and reads the outputs before the next edge and again after it. A second hard case is confirming that a shift still runs while the drivers are off. The bench checks this by shifting with the enables high and then reading bus_out, which carries the register value at all times.

// File: rtl/usr_pkg.sv
// Shared types for the universal shift register.
// Assumes a two-bit mode select, with the encodings below fixed by the interface.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DN   = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
// Turns the raw mode-select bits into the mode type and a load flag.
// Assumes mode_sel is synchronous to clk. The decode is purely combinational.
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    output usr_mode_e  mode,
    output logic       is_load
);
    // Cast the select bits to the mode type and flag load mode.
    always_comb begin
        mode    = usr_mode_e'(mode_sel);
        is_load = (mode == MODE_LOAD);
    end
endmodule

// File: rtl/usr_shift_core.sv
// W-bit register with hold, up shift, down shift and parallel load.
// Assumes an asynchronous active-low reset. Each bit slice picks its next
// value from itself, its two neighbours or the parallel input.
module usr_shift_core
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  usr_mode_e    mode,
    input  logic         ser_in_up,
    input  logic         ser_in_dn,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    localparam int TOP = W - 1;

    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_lo
            assign from_below = ser_in_up;
        end else begin : g_lo_mid
            assign from_below = q[i-1];
        end

        if (i == TOP) begin : g_hi
            assign from_above = ser_in_dn;
        end else begin : g_hi_mid
            assign from_above = q[i+1];
        end

        // Select this bit's next value from the decoded mode.
        always_comb begin
            unique case (mode)
                MODE_UP:   nxt[i] = from_below;
                MODE_DN:   nxt[i] = from_above;
                MODE_LOAD: nxt[i] = par_in[i];
                default:   nxt[i] = q[i];
            endcase
        end
    end

    // State register: cleared at once by reset, otherwise updated on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/usr_bus_ctl.sv
// Driver-enable logic for the shared parallel bus.
// Assumes both enables are active low. The drivers are released when either
// enable is high, and also in load mode so that an outside source can drive the pins.
module usr_bus_ctl (
    input  logic oe_a_n,
    input  logic oe_b_n,
    input  logic is_load,
    output logic bus_oe
);
    // Drive only when both enables are asserted and no load is selected.
    always_comb begin
        bus_oe = !(oe_a_n || oe_b_n) && !is_load;
    end
endmodule

// File: rtl/usr_shift_reg.sv
// Top of the universal shift register with a shared parallel bus.
// The bidirectional bus is split into bus_in, bus_out and bus_oe for the pad ring.
// The serial end bits leave on dedicated outputs, which are never disabled.
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_sel,
    input  logic         ser_in_up,
    input  logic         ser_in_dn,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         ser_out_lo,
    output logic         ser_out_hi
);
    usr_mode_e    mode;
    logic         is_load;
    logic [W-1:0] q;

    usr_mode_dec u_dec (
        .mode_sel (mode_sel),
        .mode     (mode),
        .is_load  (is_load)
    );

    usr_shift_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ser_in_up (ser_in_up),
        .ser_in_dn (ser_in_dn),
        .par_in    (bus_in),
        .q         (q)
    );

    usr_bus_ctl u_bus (
        .oe_a_n  (oe_a_n),
        .oe_b_n  (oe_b_n),
        .is_load (is_load),
        .bus_oe  (bus_oe)
    );

    // Send the register contents to the bus and to the serial end outputs.
    always_comb begin
        bus_out    = q;
        ser_out_lo = q[0];
        ser_out_hi = q[W-1];
    end
endmodule

// File: rtl/usr_shift_reg_chk.sv
// Assertion checker for usr_shift_reg. It is attached with a bind statement and
// watches only the top-level ports.
module usr_shift_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_sel,
    input logic         ser_in_up,
    input logic         ser_in_dn,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         ser_out_lo,
    input logic         ser_out_hi
);
    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> (!rst_n || bus_out == $past(bus_in)));

    a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |=> (!rst_n || bus_out == {$past(bus_out[W-2:0]), $past(ser_in_up)}));

    a_r3_shift_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |=> (!rst_n || bus_out == {$past(ser_in_dn), $past(bus_out[W-1:1])}));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> (!rst_n || $stable(bus_out)));

    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (bus_out == '0));

    a_r6_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_oe);

    a_r7_load_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> !bus_oe);

    a_r10_serial_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_out_lo == bus_out[0]) && (ser_out_hi == bus_out[W-1]));
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .ser_in_up  (ser_in_up),
    .ser_in_dn  (ser_in_dn),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .ser_out_lo (ser_out_lo),
    .ser_out_hi (ser_out_hi)
);

// File: tb/tb_usr_shift_reg.sv
`timescale 1ns/100ps
// Directed bench for usr_shift_reg. Each task runs one scenario and checks its results.
module tb_usr_shift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         ser_in_up = 1'b0;
    logic         ser_in_dn = 1'b0;
    logic         oe_a_n = 1'b0;
    logic         oe_b_n = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe;
    logic         ser_out_lo;
    logic         ser_out_hi;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] model = '0;

    always #2 clk = ~clk;

    usr_shift_reg #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ser_in_up(ser_in_up), .ser_in_dn(ser_in_dn),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe),
        .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Check both serial end outputs against the model (R10).
    task automatic chk_ends(input string tag);
        chk({tag, " R10 lo"}, W'(ser_out_lo), W'(model[0]));
        chk({tag, " R10 hi"}, W'(ser_out_hi), W'(model[W-1]));
    endtask

    // One clock: drive at the falling edge, update the model, sample 1 ns after the rise.
    // The bench drives bus_in only once the block has released the bus.
    task automatic step(input logic [1:0] m, input logic up, input logic dn, input logic [W-1:0] d);
        @(negedge clk);
        mode_sel  = m;
        ser_in_up = up;
        ser_in_dn = dn;
        bus_in    = '0;
        #1;
        if (m == 2'b11) begin
            chk("R7 bus released in load", W'(bus_oe), W'(0));
            bus_in = d;
        end
        case (m)
            2'b01:   model = {model[W-2:0], up};
            2'b10:   model = {dn, model[W-1:1]};
            2'b11:   model = d;
            default: model = model;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        model = '0;
        chk("R5 reset state", bus_out, '0);
        chk_ends("reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        oe_a_n = 1'b0; oe_b_n = 1'b0;
        step(2'b11, 1'b0, 1'b0, 8'hA5);
        chk("R1 load A5", bus_out, model);
        chk_ends("load A5");
        step(2'b11, 1'b1, 1'b1, 8'h3C);
        chk("R1 load 3C", bus_out, model);
        step(2'b00, 1'b0, 1'b0, '0);
        chk("R8 drive in hold", W'(bus_oe), W'(1));
        chk("R8 bus_out value", bus_out, 8'h3C);
    endtask

    task automatic t_shift_up();
        logic [W-1:0] pat = 8'b1011_0010;
        step(2'b11, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < W; i++) begin
            step(2'b01, pat[i], ~pat[i], 8'hFF);
            chk("R2 shift up", bus_out, model);
            chk_ends("shift up");
        end
        chk("R2 serial pattern in", bus_out, {pat[0], pat[1], pat[2], pat[3], pat[4], pat[5], pat[6], pat[7]});
        chk("R8 drive in up shift", W'(bus_oe), W'(1));
    endtask

    task automatic t_shift_dn();
        step(2'b11, 1'b0, 1'b0, 8'h81);
        for (int i = 0; i < W + 2; i++) begin
            step(2'b10, i[0], (i % 3) == 0, 8'hFF);
            chk("R3 shift down", bus_out, model);
            chk_ends("shift down");
        end
    endtask

    task automatic t_hold();
        step(2'b11, 1'b0, 1'b0, 8'h5A);
        for (int i = 0; i < 4; i++) begin
            step(2'b00, i[0], ~i[0], 8'hFF);
            chk("R4 hold", bus_out, 8'h5A);
        end
        chk_ends("hold");
    endtask

    task automatic t_enables();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            mode_sel = 2'b00;
            oe_a_n = c[0];
            oe_b_n = c[1];
            #1;
            chk("R6/R8 enable combo", W'(bus_oe), W'(c == 0));
        end
        oe_a_n = 1'b1; oe_b_n = 1'b0;
        step(2'b11, 1'b0, 1'b0, 8'hC3);
        chk("R9 load while off", bus_out, 8'hC3);
        step(2'b01, 1'b1, 1'b0, '0);
        chk("R9 up shift while off", bus_out, 8'h87);
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        step(2'b10, 1'b0, 1'b1, '0);
        chk("R9 down shift while off", bus_out, 8'hC3);
        chk("R6 still off", W'(bus_oe), W'(0));
        oe_b_n = 1'b0;
    endtask

    task automatic t_async_reset();
        step(2'b11, 1'b0, 1'b0, 8'hFF);
        chk("R1 load FF", bus_out, 8'hFF);
        @(negedge clk);
        mode_sel = 2'b11;
        bus_in   = 8'hFF;
        rst_n    = 1'b0;
        #0.5;
        model = '0;
        chk("R5 async clear before edge", bus_out, '0);
        chk_ends("async reset");
        @(posedge clk);
        #1;
        chk("R5 reset beats load", bus_out, '0);
        chk("R9 reset with released bus", W'(bus_oe), W'(0));
        @(negedge clk);
        mode_sel = 2'b00;
        bus_in   = '0;
        rst_n    = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_load();
        t_shift_up();
        t_shift_dn();
        t_hold();
        t_enables();
        t_async_reset();
        t_load();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule